// File: doc/BRIEF.md
# Conditioned Event Counter Pair

This block is one performance-monitoring counter together with its 32-bit control word. In each cycle it takes a small bundle of event lanes. Every lane carries a multi-bit increment and a set of sub-event flags. The control word picks one lane by number and qualifies it with a mask over that lane's flags, which gives the cycle's raw increment. That increment then goes through a programmable conditioning chain before it reaches a 44-bit wrapping accumulator.

The chain has three steps in series: a threshold compare, an optional inversion of the compare, and an optional conversion of the result into a transition count. When the threshold field is zero the chain is bypassed and the raw increment is summed. When the threshold is nonzero, each qualifying cycle or transition adds exactly one.

Software programs the block through a small write port, which reaches either the control word or the data register, and it can read both at any time without disturbing collection. A surrounding monitoring box supplies an enable and a freeze input that gate counting for every counter it owns.

Top module: `evt_cond_counter`

## Requirements
- R1: After reset, the control readback and the count are both zero.
- R2: A write with `wr_addr`=0 stores `wr_data[31:0]` as the control word. Readback returns every stored bit except bit 17, which always reads 0.
- R3: The control fields are: lane select in bits 7:0, sub-event mask in bits 15:8, clear-on-write in bit 17, transition mode in bit 18, local enable in bit 22, inversion in bit 23 and threshold in bits 31:24. The raw increment is the value of lane k (bits k*5+4:k*5 of `ev_inc`) when the lane select equals k, k < 4, and the mask shares at least one set bit with that lane's flags (bits k*8+7:k*8 of `ev_sub`). Otherwise the raw increment is 0.
- R4: With a threshold of 0, each active cycle adds the raw increment, whatever the inversion and transition bits hold.
- R5: With a nonzero threshold and both inversion and transition mode clear, an active cycle adds 1 when the raw increment is greater than or equal to the threshold, and adds 0 otherwise.
- R6: With inversion set and transition mode clear, an active cycle adds 1 when the raw increment is below the threshold.
- R7: With transition mode set, the block adds 1 on each 0-to-1 change of the compare (increment >= threshold). With inversion also set, it adds 1 on each 1-to-0 change instead. The remembered compare state returns to 0 when the counter is cleared or while local enable is 0.
- R8: Counting happens only when local enable is 1, `box_en` is 1 and `box_frz` is 0. Otherwise the count holds its value.
- R9: A control write with bit 17 set makes the count 0 on the next cycle, taking priority over that cycle's increment.
- R10: A write with `wr_addr`=1 loads `wr_data` into the count. The count is 44 bits wide and wraps modulo 2^44.
- R11: An increment presented in a cycle shows in `cnt_rd` after the next rising clock edge. Reading has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 selects the count |
| wr_data | input | 44 | Write data (control uses bits 31:0) |
| box_en | input | 1 | Box-level counting enable |
| box_frz | input | 1 | Box-level freeze, stops counting when 1 |
| ev_inc | input | 20 | Four 5-bit lane increments |
| ev_sub | input | 32 | Four 8-bit lane sub-event flag sets |
| ctl_rd | output | 32 | Control word readback |
| cnt_rd | output | 44 | Count readback |

## Verification
Every result of this block is due one rising edge after its cause. That holds for a control write, a clear, a load of the count, and an active cycle whose conditioned increment lands in the accumulator. Edge detection adds no extra cycle, because the remembered compare state is only compared against the current cycle's compare. The bench changes inputs and samples outputs on falling edges, so after N rising edges of constant stimulus it expects exactly N conditioned additions. The transition tests toggle the lane one falling edge at a time, so each edge sees a known previous state.

// File: rtl/cec_pkg.sv
package cec_pkg;

  localparam int CTL_W = 32;

  typedef struct packed {
    logic [7:0] thr;
    logic       inv;
    logic       en;
    logic [1:0] rsv_hi;
    logic       rsv_mid;
    logic       edg;
    logic       clr;
    logic       rsv_lo;
    logic [7:0] umask;
    logic [7:0] evsel;
  } ctl_t;

  // compare step of the chain, before inversion
  function automatic logic meets_thr(input logic [7:0] inc, input logic [7:0] thr);
    return inc >= thr;
  endfunction

  // inversion and transition steps, applied after the compare
  function automatic logic cond_pulse(input logic cur, input logic prev,
                                      input logic inv, input logic edg);
    logic p;
    if (edg) p = inv ? (prev & ~cur) : (~prev & cur);
    else     p = inv ? ~cur : cur;
    return p;
  endfunction

endpackage

// File: rtl/cec_lane_sel.sv
module cec_lane_sel #(
  parameter int NUM_LANES = 4,
  parameter int INC_W     = 5,
  parameter int SUB_W     = 8
) (
  input  logic [NUM_LANES*INC_W-1:0] ev_inc,
  input  logic [NUM_LANES*SUB_W-1:0] ev_sub,
  input  logic [7:0]                 evsel,
  input  logic [SUB_W-1:0]           umask,
  output logic [INC_W-1:0]           inc_sel
);

  logic [NUM_LANES-1:0] lane_hit;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign lane_hit[k] = (evsel == 8'(k)) && |(umask & ev_sub[k*SUB_W +: SUB_W]);
  end

  always_comb begin
    inc_sel = '0;
    for (int k = 0; k < NUM_LANES; k++)
      if (lane_hit[k]) inc_sel = inc_sel | ev_inc[k*INC_W +: INC_W];
  end

  always_comb begin
    assert ($onehot0(lane_hit)) else $error("lane select hit more than one lane");
  end

endmodule

// File: rtl/cec_condition.sv
module cec_condition
  import cec_pkg::*;
#(
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic [7:0]       thr,
  input  logic             inv,
  input  logic             edg,
  input  logic             en_local,
  input  logic             active,
  input  logic             clr,
  input  logic             cfg_wr,
  output logic [INC_W-1:0] add_val,
  output logic             bypass,
  output logic             pulse
);

  logic cmp_now;
  logic cmp_prev;

  assign bypass  = (thr == 8'd0);
  assign cmp_now = meets_thr(8'(inc), thr);
  assign pulse   = cond_pulse(cmp_now, cmp_prev, inv, edg);
  assign add_val = bypass ? inc : INC_W'(pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cmp_prev <= 1'b0;
    else if (clr || !en_local)  cmp_prev <= 1'b0;
    else if (active)            cmp_prev <= cmp_now;
  end

  // R7
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edg && !bypass && active && pulse && !clr && !cfg_wr) |=> !pulse);

endmodule

// File: rtl/cec_accum.sv
module cec_accum #(
  parameter int CNT_W = 44,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  input  logic             active,
  input  logic [INC_W-1:0] add_val,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (clr)    cnt <= '0;
    else if (active) cnt <= cnt + CNT_W'(add_val);
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load && !clr) |=> $stable(cnt));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> (cnt == '0));

endmodule

// File: rtl/evt_cond_counter.sv
module evt_cond_counter
  import cec_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int INC_W     = 5,
  parameter int SUB_W     = 8,
  parameter int CNT_W     = 44
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_addr,
  input  logic [CNT_W-1:0]           wr_data,
  input  logic                       box_en,
  input  logic                       box_frz,
  input  logic [NUM_LANES*INC_W-1:0] ev_inc,
  input  logic [NUM_LANES*SUB_W-1:0] ev_sub,
  output logic [CTL_W-1:0]           ctl_rd,
  output logic [CNT_W-1:0]           cnt_rd
);

  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_CNT = 1'b1;

  ctl_t             ctl_q;
  ctl_t             ctl_wr;
  logic             cfg_wr;
  logic             cnt_load;
  logic             cnt_clr;
  logic             active;
  logic [INC_W-1:0] inc_sel;
  logic [INC_W-1:0] add_val;
  logic             bypass;
  logic             pulse;

  assign ctl_wr   = ctl_t'(wr_data[CTL_W-1:0]);
  assign cfg_wr   = wr_en && (wr_addr == ADDR_CTL);
  assign cnt_load = wr_en && (wr_addr == ADDR_CNT);
  assign cnt_clr  = cfg_wr && ctl_wr.clr;
  assign active   = ctl_q.en && box_en && !box_frz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (cfg_wr) begin
      ctl_q     <= ctl_wr;
      ctl_q.clr <= 1'b0;
    end
  end

  cec_lane_sel #(.NUM_LANES(NUM_LANES), .INC_W(INC_W), .SUB_W(SUB_W)) u_sel (
    .ev_inc (ev_inc),
    .ev_sub (ev_sub),
    .evsel  (ctl_q.evsel),
    .umask  (ctl_q.umask),
    .inc_sel(inc_sel)
  );

  cec_condition #(.INC_W(INC_W)) u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (inc_sel),
    .thr     (ctl_q.thr),
    .inv     (ctl_q.inv),
    .edg     (ctl_q.edg),
    .en_local(ctl_q.en),
    .active  (active),
    .clr     (cnt_clr),
    .cfg_wr  (cfg_wr),
    .add_val (add_val),
    .bypass  (bypass),
    .pulse   (pulse)
  );

  cec_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(wr_data),
    .clr     (cnt_clr),
    .active  (active),
    .add_val (add_val),
    .cnt     (cnt_rd)
  );

  assign ctl_rd = ctl_q;

  // R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bypass && !wr_en) |=> ((cnt_rd - $past(cnt_rd)) <= CNT_W'(1)));

  // R4
  raw_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bypass && !wr_en) |=> (cnt_rd == $past(cnt_rd) + CNT_W'($past(inc_sel))));

  // R2
  clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (ctl_rd[17] == 1'b0 && ctl_rd[31:18] == $past(wr_data[31:18])));

endmodule

// File: tb/test_evt_cond_counter.sv
`timescale 1ns/1ps
module test_evt_cond_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [43:0] wr_data = '0;
  logic        box_en = 1'b1;
  logic        box_frz = 1'b0;
  logic [19:0] ev_inc = '0;
  logic [31:0] ev_sub = '0;
  logic [31:0] ctl_rd;
  logic [43:0] cnt_rd;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_cond_counter i_evt_cond_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .box_en(box_en), .box_frz(box_frz), .ev_inc(ev_inc), .ev_sub(ev_sub),
    .ctl_rd(ctl_rd), .cnt_rd(cnt_rd)
  );

  typedef struct packed {
    logic [7:0]  thr;
    logic        inv;
    logic        en;
    logic        edg;
    logic [7:0]  umask;
    logic [7:0]  sel;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  // lanes: l0=1 (flag 01), l1=3 (flag 02), l2=20 (flag 04), l3=9 (flag 08); 10 active cycles each
  localparam vec_t VECS [13] = '{
    '{8'd0,  1'b0, 1'b1, 1'b0, 8'h04, 8'd2, 16'd200, 8'd4}, // R4 raw lane 2
    '{8'd0,  1'b0, 1'b1, 1'b0, 8'h02, 8'd1, 16'd30,  8'd3}, // R3 lane 1
    '{8'd0,  1'b0, 1'b1, 1'b0, 8'h01, 8'd1, 16'd0,   8'd3}, // R3 mask mismatch
    '{8'd0,  1'b0, 1'b1, 1'b0, 8'hFF, 8'd7, 16'd0,   8'd3}, // R3 select out of range
    '{8'd16, 1'b0, 1'b1, 1'b0, 8'h04, 8'd2, 16'd10,  8'd5}, // R5 above threshold
    '{8'd21, 1'b0, 1'b1, 1'b0, 8'h04, 8'd2, 16'd0,   8'd5}, // R5 below threshold
    '{8'd9,  1'b0, 1'b1, 1'b0, 8'h08, 8'd3, 16'd10,  8'd5}, // R5 equal boundary
    '{8'd9,  1'b1, 1'b1, 1'b0, 8'h08, 8'd3, 16'd0,   8'd6}, // R6 equal inverted
    '{8'd4,  1'b1, 1'b1, 1'b0, 8'h02, 8'd1, 16'd10,  8'd6}, // R6 below inverted
    '{8'd1,  1'b0, 1'b1, 1'b1, 8'h04, 8'd2, 16'd1,   8'd7}, // R7 constant high, one rise
    '{8'd1,  1'b1, 1'b1, 1'b1, 8'h04, 8'd2, 16'd0,   8'd7}, // R7 constant high, no fall
    '{8'd0,  1'b0, 1'b0, 1'b0, 8'h04, 8'd2, 16'd0,   8'd8}, // R8 local enable off
    '{8'd0,  1'b1, 1'b1, 1'b1, 8'h01, 8'd0, 16'd10,  8'd4}  // R4 bypass ignores inv/edge
  };

  function automatic logic [31:0] mk_ctl(input logic [7:0] thr, input logic inv, input logic en,
                                         input logic edg, input logic [7:0] um, input logic [7:0] sel,
                                         input logic clr);
    return {thr, inv, en, 2'b00, 1'b0, edg, clr, 1'b0, um, sel};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic addr, input logic [43:0] data);
    wr_addr = addr;
    wr_data = data;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 control after reset", 64'(ctl_rd), 64'd0);
    check("R1 count after reset", 64'(cnt_rd), 64'd0);

    ev_inc = {5'd9, 5'd20, 5'd3, 5'd1};
    ev_sub = {8'h08, 8'h04, 8'h02, 8'h01};
    foreach (VECS[i]) begin
      reg_write(1'b0, 44'(mk_ctl(VECS[i].thr, VECS[i].inv, VECS[i].en, VECS[i].edg,
                                 VECS[i].umask, VECS[i].sel, 1'b1)));
      repeat (10) @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(cnt_rd), 64'(VECS[i].exp));
    end

    // R2 readback with bit 17 masked
    reg_write(1'b0, 44'h0_A5C6_3412);
    check("R2 control readback", 64'(ctl_rd), 64'hA5C4_3412);

    // R7 toggling lane 0, rising edges
    ev_inc = '0;
    reg_write(1'b0, 44'(mk_ctl(8'd1, 1'b0, 1'b1, 1'b1, 8'h01, 8'd0, 1'b1)));
    for (int i = 0; i < 8; i++) begin
      ev_inc = (i % 2 == 0) ? 20'd1 : 20'd0;
      @(negedge clk);
    end
    check("R7 rising transitions", 64'(cnt_rd), 64'd4);

    // R7 toggling lane 0, falling edges with inversion
    ev_inc = '0;
    reg_write(1'b0, 44'(mk_ctl(8'd1, 1'b1, 1'b1, 1'b1, 8'h01, 8'd0, 1'b1)));
    for (int i = 0; i < 8; i++) begin
      ev_inc = (i % 2 == 0) ? 20'd1 : 20'd0;
      @(negedge clk);
    end
    check("R7 falling transitions", 64'(cnt_rd), 64'd4);

    // R7 remembered state cleared while disabled
    ev_inc = 20'd1;
    reg_write(1'b0, 44'(mk_ctl(8'd1, 1'b0, 1'b1, 1'b1, 8'h01, 8'd0, 1'b1)));
    repeat (3) @(negedge clk);
    check("R7 single rise on steady input", 64'(cnt_rd), 64'd1);
    reg_write(1'b0, 44'(mk_ctl(8'd1, 1'b0, 1'b0, 1'b1, 8'h01, 8'd0, 1'b0)));
    repeat (2) @(negedge clk);
    reg_write(1'b0, 44'(mk_ctl(8'd1, 1'b0, 1'b1, 1'b1, 8'h01, 8'd0, 1'b0)));
    repeat (3) @(negedge clk);
    check("R7 rise again after disable", 64'(cnt_rd), 64'd2);

    // R8 freeze and box enable, R11 one-edge latency
    ev_inc = {5'd9, 5'd20, 5'd3, 5'd1};
    reg_write(1'b0, 44'(mk_ctl(8'd0, 1'b0, 1'b1, 1'b0, 8'h04, 8'd2, 1'b1)));
    repeat (3) @(negedge clk);
    check("R8 counting before freeze", 64'(cnt_rd), 64'd60);
    box_frz = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 frozen count holds", 64'(cnt_rd), 64'd60);
    box_frz = 1'b0;
    box_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 box disable holds", 64'(cnt_rd), 64'd60);
    box_en = 1'b1;
    @(negedge clk);
    check("R11 increment after one edge", 64'(cnt_rd), 64'd80);
    check("R11 repeated read unchanged", 64'(cnt_rd), 64'd80);

    // R9 clear wins over a live increment
    reg_write(1'b0, 44'(mk_ctl(8'd0, 1'b0, 1'b1, 1'b0, 8'h04, 8'd2, 1'b1)));
    check("R9 clear overrides increment", 64'(cnt_rd), 64'd0);
    @(negedge clk);
    check("R9 counting resumes", 64'(cnt_rd), 64'd20);

    // R10 load and wrap
    reg_write(1'b1, 44'hFFF_FFFF_FFFB);
    check("R10 load value", 64'(cnt_rd), 64'hFFF_FFFF_FFFB);
    @(negedge clk);
    check("R10 wrap modulo 2^44", 64'(cnt_rd), 64'd15);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule